// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire bus slave that gives a bus master access to a small bank of configuration registers. There are fourteen addresses behind one auto-incrementing pointer. Addresses 0 to 11 hold read/write control bytes. Address 12 is a status byte built from the state of the oscillator-selection engine and a sticky power-up flag. Address 13 is a status byte that reports the chosen oscillator band and the tuning-voltage converter code. The raw bus lines are sampled in the system clock domain. The block pulls the data line low only to acknowledge or to send a zero bit, and it never stretches the clock.

A write transfer sets the pointer and stores one or more data bytes. A read transfer sets the pointer in a write phase, then a repeated START with the read bit set streams bytes out until the master answers with a NACK. A write to control register 5 raises a one-cycle start pulse for the oscillator-selection engine. Bit 7 of control register 9 drives the standby output.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave answers the 7-bit address 1,1,0,0,0,0,S, where S is the level of `addr_sel_i`, with an ACK (data line low in the ninth clock). Any other address gets a NACK.
- R2: After a NACK to an address byte, the block ignores the bus and drives nothing until the next START. Bytes sent in that time change no register.
- R3: In a write transfer the byte after the address is the pointer. Each following data byte is stored MSB first at the pointer, acknowledged, and the pointer then steps by one. All control registers reset to 0x00.
- R4: The pointer steps from 13 to 0. A pointer byte with a value above 13 selects address 0.
- R5: Data bytes written to addresses 12 and 13 are acknowledged, but they change nothing. The pointer still advances.
- R6: After a repeated START with the read bit set, the slave returns the byte at the pointer, MSB first, and steps the pointer after each byte. Each master ACK fetches the next byte. A master NACK ends the read, and the slave has released the data line by the end of that bit.
- R7: Status byte 1 (address 12) is {power-up flag, `vas_found_i`, NOT `vas_busy_i`, `pll_lock_i`, 0000}, bit 7 first.
- R8: Status byte 2 (address 13) is {`vco_band_i`[4:0], `tune_adc_i`[2:0]}.
- R9: The power-up flag is 1 after reset. It goes to 0 only when a transfer in which status byte 1 was sent ends with STOP. Reads of other registers leave it set, and nothing sets it again before the next reset.
- R10: Every data byte written at address 5 gives exactly one `vas_start_o` pulse, one cycle wide. Writes to other addresses give none.
- R11: `standby_o` equals bit 7 of control register 9.
- R12: A STOP releases the data line, and the slave never drives it while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Strap that sets the low bit of the slave address |
| vas_busy_i | input | 1 | Oscillator-selection search is running |
| vas_found_i | input | 1 | Last search found a valid oscillator |
| pll_lock_i | input | 1 | Synthesizer lock indication |
| vco_band_i | input | 5 | Selected oscillator band |
| tune_adc_i | input | 3 | Tuning-voltage converter code |
| sda_drive_low_o | output | 1 | When 1, the pad pulls the data line low |
| ctrl_regs_o | output | 96 | Control registers; register k is in bits 8k+7:8k |
| standby_o | output | 1 | Standby request |
| vas_start_o | output | 1 | One-cycle start pulse for the oscillator search |

## Verification
A wrong pointer shows up within one byte. Either the next read returns a neighbouring register, or a burst write lands one address off in `ctrl_regs_o` at the ninth clock edge of that byte. A wrong bit counter or wrong bus state shows up as a missing or misplaced ACK on the very next byte, or as a data line that is still pulled low after STOP. The power-up flag is only visible through a later status read, so a flag that clears at the wrong time is caught one transfer late.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int          NUM_RW   = 12,
  parameter logic [5:0]  DEV_HI   = 6'b110000,
  parameter int          VAS_REG  = 5,
  parameter int          STBY_REG = 9,
  parameter int          STBY_BIT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               addr_sel_i,
  input  logic               vas_busy_i,
  input  logic               vas_found_i,
  input  logic               pll_lock_i,
  input  logic [4:0]         vco_band_i,
  input  logic [2:0]         tune_adc_i,
  output logic               sda_drive_low_o,
  output logic [NUM_RW*8-1:0] ctrl_regs_o,
  output logic               standby_o,
  output logic               vas_start_o
);
  localparam int NUM_ALL = NUM_RW + 2;
  localparam int PW      = $clog2(NUM_ALL);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_ADDR = 3'd1, ST_PTR = 3'd2,
                         ST_WR   = 3'd3, ST_RD   = 3'd4;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  logic [2:0]    st_q;
  logic [PW-1:0] ptr_q;
  logic [7:0]    sh_q;
  logic [3:0]    cnt_q;
  logic          in_ack_q, mack_q, drv_q, por_q, stat_rd_q, vas_q;
  logic [7:0]    regs_q [NUM_RW];
  logic [7:0]    rd_byte;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_ev = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise     = scl_s & ~scl_q;
  wire fall     = ~scl_s & scl_q;
  wire bus_idle = (st_q == ST_IDLE);
  wire addr_hit = (sh_q[7:1] == {DEV_HI, addr_sel_i});
  wire [PW-1:0] ptr_nxt = (ptr_q == PW'(NUM_ALL - 1)) ? '0 : ptr_q + 1'b1;
  wire [7:0] status1 = {por_q, vas_found_i, ~vas_busy_i, pll_lock_i, 4'b0000};

  always_comb begin
    rd_byte = {vco_band_i, tune_adc_i};
    if (ptr_q == PW'(NUM_RW)) rd_byte = status1;
    for (int i = 0; i < NUM_RW; i++)
      if (ptr_q == PW'(i)) rd_byte = regs_q[i];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_RW; g++) begin : g_out
      assign ctrl_regs_o[g*8 +: 8] = regs_q[g];
    end
  endgenerate

  assign standby_o       = regs_q[STBY_REG][STBY_BIT];
  assign vas_start_o     = vas_q;
  assign sda_drive_low_o = drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      sh_q      <= '0;
      cnt_q     <= '0;
      in_ack_q  <= 1'b0;
      mack_q    <= 1'b0;
      drv_q     <= 1'b0;
      por_q     <= 1'b1;
      stat_rd_q <= 1'b0;
      vas_q     <= 1'b0;
      for (int i = 0; i < NUM_RW; i++) regs_q[i] <= '0;
    end else begin
      vas_q <= 1'b0;
      if (start_ev) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        drv_q    <= 1'b0;
      end else if (stop_ev) begin
        st_q      <= ST_IDLE;
        in_ack_q  <= 1'b0;
        drv_q     <= 1'b0;
        stat_rd_q <= 1'b0;
        if (stat_rd_q) por_q <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (rise) begin
          if (in_ack_q) mack_q <= ~sda_s;
          else if (cnt_q != 4'd8) begin
            cnt_q <= cnt_q + 1'b1;
            if (st_q != ST_RD) sh_q <= {sh_q[6:0], sda_s};
          end
        end else if (fall) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            cnt_q    <= '0;
            drv_q    <= 1'b0;
            if (st_q == ST_RD) begin
              if (mack_q) begin
                sh_q  <= rd_byte;
                drv_q <= ~rd_byte[7];
                ptr_q <= ptr_nxt;
                if (ptr_q == PW'(NUM_RW)) stat_rd_q <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end else if (cnt_q == 4'd8) begin
            in_ack_q <= 1'b1;
            case (st_q)
              ST_ADDR: begin
                if (addr_hit) begin
                  drv_q <= 1'b1;
                  st_q  <= sh_q[0] ? ST_RD : ST_PTR;
                end else begin
                  drv_q <= 1'b0;
                  st_q  <= ST_IDLE;
                end
              end
              ST_PTR: begin
                drv_q <= 1'b1;
                ptr_q <= (sh_q < 8'(NUM_ALL)) ? sh_q[PW-1:0] : '0;
                st_q  <= ST_WR;
              end
              ST_WR: begin
                drv_q <= 1'b1;
                for (int i = 0; i < NUM_RW; i++)
                  if (ptr_q == PW'(i)) regs_q[i] <= sh_q;
                if (ptr_q == PW'(VAS_REG)) vas_q <= 1'b1;
                ptr_q <= ptr_nxt;
              end
              default: drv_q <= 1'b0;
            endcase
          end else if (st_q == ST_RD && cnt_q != 4'd0) begin
            sh_q  <= {sh_q[6:0], 1'b0};
            drv_q <= ~sh_q[6];
          end
        end
      end
    end
  end
endmodule

module i2c_cfg_slave_chk #(
  parameter int NUM_RW = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_idle,
  input logic               stop_ev,
  input logic               por_q,
  input logic               sda_drive_low_o,
  input logic               vas_start_o,
  input logic [NUM_RW*8-1:0] ctrl_regs_o
);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vas_start_o |=> !vas_start_o);
  a_r9_por_never_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !por_q |=> !por_q);
  a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_drive_low_o);
  a_r2_silent_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_drive_low_o);
  a_r3_idle_regs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |=> $stable(ctrl_regs_o));
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NUM_RW(NUM_RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .stop_ev(stop_ev),
  .por_q(por_q), .sda_drive_low_o(sda_drive_low_o),
  .vas_start_o(vas_start_o), .ctrl_regs_o(ctrl_regs_o)
);

// File: tb/i2c_cfg_slave_tb.sv
`timescale 1ns/1ps
module i2c_cfg_slave_tb;
  localparam int H = 8;
  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1, addr_sel = 0;
  logic busy = 0, found = 0, lock = 0;
  logic [4:0] band = 0;
  logic [2:0] adc = 0;
  logic drv, stby, vas;
  logic [95:0] regs;
  wire sda_bus = m_sda & ~drv;

  always #2.5 clk = ~clk;

  i2c_cfg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .vas_busy_i(busy), .vas_found_i(found),
    .pll_lock_i(lock), .vco_band_i(band), .tune_adc_i(adc),
    .sda_drive_low_o(drv), .ctrl_regs_o(regs), .standby_o(stby),
    .vas_start_o(vas));

  int checks = 0, fails = 0, vas_exp = 0, vas_hi = 0, vas_rise = 0;
  logic vas_prev = 0, por_exp = 1, done = 0;
  logic [7:0] mreg [12];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always @(posedge clk) if (rst_n) begin
    if (vas) vas_hi++;
    if (vas && !vas_prev) vas_rise++;
    vas_prev = vas;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start; m_sda = 1; hw(H); m_scl = 1; hw(H); m_sda = 0; hw(H); m_scl = 0; hw(H); endtask
  task automatic bus_stop;  m_sda = 0; hw(H); m_scl = 1; hw(H); m_sda = 1; hw(H); endtask
  task automatic put_bit(logic b); m_sda = b; hw(H); m_scl = 1; hw(H); m_scl = 0; endtask
  task automatic get_bit(output logic b);
    m_sda = 1; hw(H); m_scl = 1; hw(H/2); b = sda_bus; hw(H/2); m_scl = 0;
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nb);
    ack = ~nb;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~mack);
  endtask

  function automatic logic [7:0] exp_rd(int q);
    if (q < 12) return mreg[q];
    if (q == 12) return {por_exp, found, ~busy, lock, 4'b0000};
    return {band, adc};
  endfunction
  function automatic int norm_ptr(logic [7:0] p); return (p < 14) ? int'(p) : 0; endfunction
  function automatic logic [7:0] dev(logic rd); return {6'b110000, addr_sel, rd}; endfunction

  task automatic do_write(logic [7:0] p, int n);
    logic ack;
    int q = norm_ptr(p);
    bus_start;
    send_byte(dev(0), ack); check("R1 write address ack", ack, 1);
    send_byte(p, ack);      check("R3 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check(q >= 12 ? "R5 read-only write ack" : "R3 data ack", ack, 1);
      if (q < 12) mreg[q] = wbuf[i];
      if (q == 5) vas_exp++;
      q = (q == 13) ? 0 : q + 1;
    end
    bus_stop;
  endtask

  task automatic do_read(logic [7:0] p, int n);
    logic ack;
    int q = norm_ptr(p);
    logic saw_s1 = 0;
    bus_start;
    send_byte(dev(0), ack); check("R1 address ack", ack, 1);
    send_byte(p, ack);      check("R6 pointer ack", ack, 1);
    bus_start;
    send_byte(dev(1), ack); check("R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(rbuf[i], i != n - 1);
      if (q == 12) begin check("R7 status1", rbuf[i], exp_rd(12)); saw_s1 = 1; end
      else if (q == 13) check("R8 status2", rbuf[i], exp_rd(13));
      else check("R6 read data", rbuf[i], exp_rd(q));
      q = (q == 13) ? 0 : q + 1;
    end
    hw(4);
    check("R6 released after nack", drv, 0);
    bus_stop;
    hw(4);
    check("R12 released after stop", drv, 0);
    if (saw_s1) por_exp = 0;
  endtask

  task automatic check_regs(string tag);
    for (int i = 0; i < 12; i++) check(tag, regs[i*8 +: 8], mreg[i]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run;
  end

  initial begin
    logic ack;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 12; i++) mreg[i] = 0;
    hw(5); rst_n = 1; hw(5);
    check_regs("R3 reset value");
    check("R11 standby after reset", stby, 0);
    check("R12 idle drive", drv, 0);

    found = 1; busy = 0; lock = 1; band = 5'h15; adc = 3'b010;
    do_read(8'd0, 1);
    check("R9 por kept after other read", por_exp, 1);
    do_read(8'd12, 2);
    do_read(8'd12, 1);
    check("R9 por cleared", rbuf[0][7], 0);

    bus_start;
    send_byte(8'hC2, ack); check("R1 foreign address nack", ack, 0);
    send_byte(8'h02, ack); check("R2 ignored byte", ack, 0);
    send_byte(8'h5A, ack); check("R2 ignored byte", ack, 0);
    bus_stop;
    check_regs("R2 no write");

    addr_sel = 1;
    wbuf[0] = 8'h3C; do_write(8'd3, 1);
    check_regs("R1 strap address write");
    bus_start;
    send_byte(8'hC0, ack); check("R1 old address nack", ack, 0);
    bus_stop;
    do_read(8'd3, 1);
    addr_sel = 0;

    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    do_write(8'd11, 4);
    check_regs("R4 R5 wrap write");
    busy = 1; found = 0; lock = 0; band = 5'h0A; adc = 3'b101;
    do_read(8'd12, 2);
    do_read(8'd13, 3);
    wbuf[0] = 8'h77; do_write(8'h20, 1);
    check("R4 large pointer", regs[7:0], 8'h77);

    wbuf[0] = 8'h80; do_write(8'd9, 1);
    check("R11 standby set", stby, 1);
    wbuf[0] = 8'h7F; do_write(8'd9, 1);
    check("R11 standby clear", stby, 0);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'd4, 3);
    hw(4);
    check("R10 pulse count", vas_rise, vas_exp);

    for (int r = 0; r < 18; r++) begin
      int n = $urandom_range(1, 6);
      logic [7:0] p = 8'($urandom_range(0, 16));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      busy = 1'($urandom); found = 1'($urandom); lock = 1'($urandom);
      band = 5'($urandom); adc = 3'($urandom);
      do_write(p, n);
      check_regs("R3 random burst");
      check("R11 standby follows reg9", stby, mreg[9][7]);
      do_read(8'($urandom_range(0, 13)), $urandom_range(1, 4));
    end

    hw(4);
    check("R10 pulse count", vas_rise, vas_exp);
    check("R10 pulse width", vas_hi, vas_exp);
    finish_run;
  end
endmodule